// File: doc/BRIEF.md
# Bus Master Access Guard

This block sits beside the interconnect and covers every bus master other than the CPU. Each master has a one-bit privilege attribute and a one-bit security attribute, held in two vectors indexed by master number. After reset every master is privileged and Secure. When software clears a bit, that master becomes unprivileged or Non-secure. Each transaction carries a master number, an address and a valid strobe. Address attribution logic outside this block supplies a flag that says whether the address is Non-secure. The block drives the privilege and security tags of the current master onto the transaction.

A Non-secure master may reach Non-secure addresses only. When such a master presents a Secure address, the guard raises a deny in the same cycle. The first such violation is latched into a fault master-number register and a fault address register, and a sticky security-fault flag is set. While the flag is set, further violations are still denied but overwrite nothing. Writing the clear strobe drops the flag and re-arms capture. The interrupt line is the flag gated by an enable register. The attribute vectors accept writes only while the configuration lock input reports the configuration as open.

Top module: `master_access_guard`

## Requirements
- R1: After reset, both attribute vectors read all ones, the flag, the interrupt enable and the interrupt are 0, and both fault registers are 0.
- R2: `tag_priv_o` and `tag_sec_o` equal the privilege and security bits of the master selected by `txn_master_i`, in the same cycle.
- R3: `deny_o` is 1 in the same cycle as a transaction that has `txn_valid_i`=1, comes from a master whose security bit is 0, and has `txn_addr_ns_i`=0 (the address is Secure).
- R4: A pulse on `cfg_priv_we_i` or `cfg_sec_we_i` loads `cfg_wdata_i` into that vector at the next edge only when `cfg_open_i`=1. When `cfg_open_i`=0 the write is ignored.
- R5: `fault_flag_o` is 1 from the clock edge that ends a denied cycle.
- R6: If the flag is 0 on a denied cycle, `fault_master_o` and `fault_addr_o` take that transaction's master number and address at the same edge.
- R7: While the flag is 1 and no clear is presented, a further violation is still denied but leaves both fault registers unchanged.
- R8: A `fault_clr_i` pulse with no violation in the same cycle drops the flag at the next edge, and the next violation is captured again.
- R9: `irq_en_o` loads `irq_en_wdata_i` when `irq_en_we_i`=1. `irq_o` is 1 exactly when the flag and the enable are both 1.
- R10: When a clear and a violation fall in the same cycle, the flag stays 1 and the fault registers record the new violation.
- R11: A transaction from a Secure master, one to a Non-secure address, or one with `txn_valid_i`=0 is never denied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_open_i | input | 1 | 1 while the configuration lock is open |
| cfg_priv_we_i | input | 1 | Write strobe for the privilege vector |
| cfg_sec_we_i | input | 1 | Write strobe for the security vector |
| cfg_wdata_i | input | NUM_MASTERS | Write data; bit n belongs to master n |
| priv_attr_o | output | NUM_MASTERS | Privilege vector, 1 = privileged |
| sec_attr_o | output | NUM_MASTERS | Security vector, 1 = Secure |
| txn_valid_i | input | 1 | Transaction valid |
| txn_master_i | input | ID_W | Master number of the transaction |
| txn_addr_i | input | ADDR_W | Transaction address |
| txn_addr_ns_i | input | 1 | Attribution result, 1 = address is Non-secure |
| tag_priv_o | output | 1 | Privilege tag of the current master |
| tag_sec_o | output | 1 | Security tag of the current master |
| deny_o | output | 1 | Transaction blocked |
| fault_master_o | output | ID_W | Captured master number |
| fault_addr_o | output | ADDR_W | Captured address |
| fault_clr_i | input | 1 | Clear strobe for the fault flag |
| fault_flag_o | output | 1 | Sticky security-fault flag |
| irq_en_we_i | input | 1 | Write strobe for the interrupt enable |
| irq_en_wdata_i | input | 1 | Interrupt enable write value |
| irq_en_o | output | 1 | Interrupt enable |
| irq_o | output | 1 | Interrupt request |

## Verification
Software clearing the flag and a new violation can fall in the same cycle, and this is the case that decides whether a fault is lost. The bench first leaves a fault latched. In a single cycle it then drives the clear strobe together with a denied transaction that carries a new master number and address. The result passes only if, one edge later, the flag is still 1 and both fault registers hold the new transaction's values, not the earlier ones.

// File: rtl/mag_pkg.sv
package mag_pkg;

    typedef struct packed {
        logic priv;
        logic sec;
    } attr_tag_t;

    function automatic int unsigned id_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/mag_attr_table.sv
module mag_attr_table
    import mag_pkg::*;
#(
    parameter int unsigned N   = 8,
    parameter int unsigned IDW = 3
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           cfg_open_i,
    input  logic           priv_we_i,
    input  logic           sec_we_i,
    input  logic [N-1:0]   wdata_i,
    input  logic [IDW-1:0] lookup_id_i,
    output attr_tag_t      tag_o,
    output logic [N-1:0]   priv_o,
    output logic [N-1:0]   sec_o
);
    localparam int unsigned SLOTS = 1 << IDW;

    typedef struct packed {
        logic [N-1:0] priv;
        logic [N-1:0] sec;
    } table_t;

    table_t st_d, st_q;
    logic [SLOTS-1:0] priv_ext, sec_ext;

    always_comb begin
        st_d = st_q;
        if (cfg_open_i && priv_we_i) st_d.priv = wdata_i;
        if (cfg_open_i && sec_we_i)  st_d.sec  = wdata_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.priv <= '1;
            st_q.sec  <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    // Unused master numbers read as privileged and Secure.
    generate
        if (SLOTS > N) begin : g_pad
            assign priv_ext = {{(SLOTS-N){1'b1}}, st_q.priv};
            assign sec_ext  = {{(SLOTS-N){1'b1}}, st_q.sec};
        end else begin : g_exact
            assign priv_ext = st_q.priv;
            assign sec_ext  = st_q.sec;
        end
    endgenerate

    assign tag_o.priv = priv_ext[lookup_id_i];
    assign tag_o.sec  = sec_ext[lookup_id_i];
    assign priv_o     = st_q.priv;
    assign sec_o      = st_q.sec;

    // R4: a closed lock freezes both vectors
    a_r4_locked_table: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cfg_open_i |=> ($stable(st_q.priv) && $stable(st_q.sec)));

endmodule

// File: rtl/mag_access_check.sv
module mag_access_check (
    input  logic txn_valid_i,
    input  logic master_sec_i,
    input  logic addr_ns_i,
    output logic deny_o
);
    always_comb begin
        deny_o = 1'b0;
        if (txn_valid_i && !master_sec_i && !addr_ns_i) deny_o = 1'b1;
    end
endmodule

// File: rtl/mag_fault_log.sv
module mag_fault_log #(
    parameter int unsigned IDW = 3,
    parameter int unsigned AW  = 32
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           viol_i,
    input  logic [IDW-1:0] viol_id_i,
    input  logic [AW-1:0]  viol_addr_i,
    input  logic           clr_i,
    input  logic           ien_we_i,
    input  logic           ien_wdata_i,
    output logic           flag_o,
    output logic           ien_o,
    output logic           irq_o,
    output logic [IDW-1:0] fault_id_o,
    output logic [AW-1:0]  fault_addr_o
);
    typedef struct packed {
        logic           flag;
        logic           ien;
        logic [IDW-1:0] id;
        logic [AW-1:0]  addr;
    } log_t;

    log_t st_d, st_q;
    logic armed;

    always_comb begin
        st_d  = st_q;
        // A clear in the same cycle re-arms capture for that cycle's violation.
        armed = !st_q.flag || clr_i;
        if (clr_i) st_d.flag = 1'b0;
        if (viol_i) begin
            st_d.flag = 1'b1;
            if (armed) begin
                st_d.id   = viol_id_i;
                st_d.addr = viol_addr_i;
            end
        end
        if (ien_we_i) st_d.ien = ien_wdata_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign flag_o       = st_q.flag;
    assign ien_o        = st_q.ien;
    assign irq_o        = st_q.flag && st_q.ien;
    assign fault_id_o   = st_q.id;
    assign fault_addr_o = st_q.addr;

    // R5: a violation always leaves the flag set
    a_r5_flag_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
        viol_i |=> st_q.flag);

    // R7: a set flag without a clear holds both fault registers
    a_r7_hold_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.flag && !clr_i) |=> ($stable(st_q.id) && $stable(st_q.addr)));

    // R8: a clear with no violation drops the flag
    a_r8_clear_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i && !viol_i) |=> !st_q.flag);

    // R10: a clear and a violation together capture the new fault
    a_r10_collide_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i && viol_i) |=> (st_q.id == $past(viol_id_i) && st_q.addr == $past(viol_addr_i)));

endmodule

// File: rtl/master_access_guard.sv
module master_access_guard
    import mag_pkg::*;
#(
    parameter int unsigned NUM_MASTERS = 8,
    parameter int unsigned ADDR_W      = 32,
    localparam int unsigned ID_W       = id_width(NUM_MASTERS)
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   cfg_open_i,
    input  logic                   cfg_priv_we_i,
    input  logic                   cfg_sec_we_i,
    input  logic [NUM_MASTERS-1:0] cfg_wdata_i,
    output logic [NUM_MASTERS-1:0] priv_attr_o,
    output logic [NUM_MASTERS-1:0] sec_attr_o,
    input  logic                   txn_valid_i,
    input  logic [ID_W-1:0]        txn_master_i,
    input  logic [ADDR_W-1:0]      txn_addr_i,
    input  logic                   txn_addr_ns_i,
    output logic                   tag_priv_o,
    output logic                   tag_sec_o,
    output logic                   deny_o,
    output logic [ID_W-1:0]        fault_master_o,
    output logic [ADDR_W-1:0]      fault_addr_o,
    input  logic                   fault_clr_i,
    output logic                   fault_flag_o,
    input  logic                   irq_en_we_i,
    input  logic                   irq_en_wdata_i,
    output logic                   irq_en_o,
    output logic                   irq_o
);
    attr_tag_t cur_tag;
    logic      deny;

    mag_attr_table #(.N(NUM_MASTERS), .IDW(ID_W)) u_table (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .cfg_open_i  (cfg_open_i),
        .priv_we_i   (cfg_priv_we_i),
        .sec_we_i    (cfg_sec_we_i),
        .wdata_i     (cfg_wdata_i),
        .lookup_id_i (txn_master_i),
        .tag_o       (cur_tag),
        .priv_o      (priv_attr_o),
        .sec_o       (sec_attr_o)
    );

    mag_access_check u_check (
        .txn_valid_i  (txn_valid_i),
        .master_sec_i (cur_tag.sec),
        .addr_ns_i    (txn_addr_ns_i),
        .deny_o       (deny)
    );

    mag_fault_log #(.IDW(ID_W), .AW(ADDR_W)) u_log (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .viol_i       (deny),
        .viol_id_i    (txn_master_i),
        .viol_addr_i  (txn_addr_i),
        .clr_i        (fault_clr_i),
        .ien_we_i     (irq_en_we_i),
        .ien_wdata_i  (irq_en_wdata_i),
        .flag_o       (fault_flag_o),
        .ien_o        (irq_en_o),
        .irq_o        (irq_o),
        .fault_id_o   (fault_master_o),
        .fault_addr_o (fault_addr_o)
    );

    assign tag_priv_o = cur_tag.priv;
    assign tag_sec_o  = cur_tag.sec;
    assign deny_o     = deny;

    // R3 and R11: a deny only ever comes from a Non-secure master on a Secure address
    a_r3_deny_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
        deny_o |-> (txn_valid_i && !tag_sec_o && !txn_addr_ns_i));

    // R9: no interrupt without a latched fault
    a_r9_irq_needs_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> (fault_flag_o && irq_en_o));

endmodule

// File: tb/master_access_guard_test.sv
module master_access_guard_test;
    localparam int unsigned NM = 8;
    localparam int unsigned AW = 32;
    localparam int unsigned IW = 3;
    localparam time CLK_PERIOD = 10ns;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_open = 1'b0, cfg_priv_we = 1'b0, cfg_sec_we = 1'b0;
    logic [NM-1:0] cfg_wdata = '0;
    logic [NM-1:0] priv_attr, sec_attr;
    logic txn_valid = 1'b0;
    logic [IW-1:0] txn_master = '0;
    logic [AW-1:0] txn_addr = '0;
    logic txn_addr_ns = 1'b0;
    logic tag_priv, tag_sec, deny;
    logic [IW-1:0] fault_master;
    logic [AW-1:0] fault_addr;
    logic fault_clr = 1'b0, fault_flag;
    logic ien_we = 1'b0, ien_wdata = 1'b0, irq_en, irq;

    int checks = 0;
    int fails = 0;
    logic [NM-1:0] exp_priv, exp_sec;

    always #(CLK_PERIOD/2) clk = ~clk;

    master_access_guard #(.NUM_MASTERS(NM), .ADDR_W(AW)) uut (
        .clk_i(clk), .rst_ni(rst_n),
        .cfg_open_i(cfg_open), .cfg_priv_we_i(cfg_priv_we), .cfg_sec_we_i(cfg_sec_we),
        .cfg_wdata_i(cfg_wdata), .priv_attr_o(priv_attr), .sec_attr_o(sec_attr),
        .txn_valid_i(txn_valid), .txn_master_i(txn_master), .txn_addr_i(txn_addr),
        .txn_addr_ns_i(txn_addr_ns), .tag_priv_o(tag_priv), .tag_sec_o(tag_sec),
        .deny_o(deny), .fault_master_o(fault_master), .fault_addr_o(fault_addr),
        .fault_clr_i(fault_clr), .fault_flag_o(fault_flag),
        .irq_en_we_i(ien_we), .irq_en_wdata_i(ien_wdata), .irq_en_o(irq_en), .irq_o(irq)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Advance one edge; inputs change and outputs are sampled between edges.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 priv", priv_attr, {NM{1'b1}});
        chk("R1 sec", sec_attr, {NM{1'b1}});
        chk("R1 flag", fault_flag, 0);
        chk("R1 irq_en", irq_en, 0);
        chk("R1 irq", irq, 0);
        chk("R1 fault master", fault_master, 0);
        chk("R1 fault addr", fault_addr, 0);
    endtask

    task automatic t_lock();
        cfg_open = 1'b0; cfg_priv_we = 1'b1; cfg_wdata = 8'h0F;
        step();
        cfg_priv_we = 1'b0;
        chk("R4 locked priv write ignored", priv_attr, {NM{1'b1}});
        cfg_open = 1'b1; cfg_priv_we = 1'b1; cfg_wdata = 8'h55;
        step();
        cfg_priv_we = 1'b0;
        chk("R4 open priv write", priv_attr, 8'h55);
        cfg_sec_we = 1'b1; cfg_wdata = 8'hF0;
        step();
        cfg_sec_we = 1'b0;
        chk("R4 open sec write", sec_attr, 8'hF0);
        cfg_open = 1'b0; cfg_sec_we = 1'b1; cfg_wdata = 8'h00;
        step();
        cfg_sec_we = 1'b0;
        chk("R4 locked sec write ignored", sec_attr, 8'hF0);
        exp_priv = 8'h55;
        exp_sec  = 8'hF0;
    endtask

    task automatic t_tags();
        txn_valid = 1'b1; txn_addr_ns = 1'b1; txn_addr = 32'h0000_4000;
        for (int m = 0; m < NM; m++) begin
            txn_master = m[IW-1:0];
            #1;
            chk("R2 priv tag", tag_priv, exp_priv[m]);
            chk("R2 sec tag", tag_sec, exp_sec[m]);
            chk("R11 ns address never denied", deny, 0);
        end
        txn_valid = 1'b0;
        step();
        chk("R11 no flag after legal traffic", fault_flag, 0);
    endtask

    task automatic t_first_fault();
        txn_valid = 1'b1; txn_master = 3'd5; txn_addr_ns = 1'b0; txn_addr = 32'h1000_0000;
        #1 chk("R11 secure master allowed", deny, 0);
        txn_valid = 1'b0; txn_master = 3'd2;
        #1 chk("R11 invalid not denied", deny, 0);
        txn_valid = 1'b1; txn_addr = 32'h0000_1234;
        #1 chk("R3 ns master on secure address", deny, 1);
        step();
        txn_valid = 1'b0;
        chk("R5 flag set", fault_flag, 1);
        chk("R6 master captured", fault_master, 2);
        chk("R6 address captured", fault_addr, 32'h0000_1234);
        chk("R9 irq off while disabled", irq, 0);
    endtask

    task automatic t_hold();
        txn_valid = 1'b1; txn_master = 3'd3; txn_addr = 32'h0000_BEEF; txn_addr_ns = 1'b0;
        #1 chk("R7 later violation still denied", deny, 1);
        step();
        txn_valid = 1'b0;
        chk("R7 master held", fault_master, 2);
        chk("R7 address held", fault_addr, 32'h0000_1234);
    endtask

    task automatic t_irq();
        ien_we = 1'b1; ien_wdata = 1'b1;
        step();
        ien_we = 1'b0;
        chk("R9 enable readback", irq_en, 1);
        chk("R9 irq with flag and enable", irq, 1);
        ien_we = 1'b1; ien_wdata = 1'b0;
        step();
        chk("R9 irq off when disabled", irq, 0);
        ien_wdata = 1'b1;
        step();
        ien_we = 1'b0;
    endtask

    task automatic t_clear();
        fault_clr = 1'b1;
        step();
        fault_clr = 1'b0;
        chk("R8 flag cleared", fault_flag, 0);
        chk("R9 irq drops with flag", irq, 0);
        txn_valid = 1'b1; txn_master = 3'd1; txn_addr = 32'h0000_0077; txn_addr_ns = 1'b0;
        step();
        txn_valid = 1'b0;
        chk("R8 re-armed flag", fault_flag, 1);
        chk("R8 re-armed master", fault_master, 1);
        chk("R8 re-armed address", fault_addr, 32'h0000_0077);
    endtask

    task automatic t_collide();
        fault_clr = 1'b1;
        txn_valid = 1'b1; txn_master = 3'd0; txn_addr = 32'h0000_CAFE; txn_addr_ns = 1'b0;
        step();
        fault_clr = 1'b0; txn_valid = 1'b0;
        chk("R10 flag stays set", fault_flag, 1);
        chk("R10 new master recorded", fault_master, 0);
        chk("R10 new address recorded", fault_addr, 32'h0000_CAFE);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_lock();
        t_tags();
        t_first_fault();
        t_hold();
        t_irq();
        t_clear();
        t_collide();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule